// File: doc/BRIEF.md
# SPI Flash Burst-Read Sequencer

This block sits on the host side of a single-bit SPI link to a serial flash and performs one burst read per request. A request carries a 24-bit start address, a byte count (given as count minus one), and a two-bit mode code that picks one of three read flavours. Each flavour has its own command code, its own number of dummy bytes after the address, and its own serial clock speed. The block lowers chip select, sends the command and the address and pads with dummy bytes. It then clocks in the requested number of bytes and hands each one out on a valid/ready byte stream. Finally it raises chip select again.

The serial clock comes from an internal divider that counts system clock cycles per SCK half-period. The slow flavour uses a longer half-period than the other two. When the downstream consumer holds back a byte, the serial clock freezes, so no data is lost. The block does not limit the count at the top of the array: a burst that starts near the last address simply keeps clocking, and the flash wraps back to address zero.

Top module: `spi_burst_reader`

## Requirements
- R1: `req_ready` is high exactly while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `busy` is high from the next cycle until the cycle in which `spi_cs_n` returns high. A request presented while busy is not taken and starts no transfer.
- R2: Mode code 0 (fast) sends command byte 0x0B, then the three address bytes, then one dummy byte, before any data bit is read.
- R3: Mode code 1 (high-speed) sends command byte 0x1B, then the three address bytes, then two dummy bytes.
- R4: Mode codes 2 and 3 (slow) send command byte 0x03 and the address with no dummy byte. Their SCK half-period is SLOW_HALF system clocks, while modes 0 and 1 use FAST_HALF system clocks.
- R5: The address is sent as three bytes, most significant byte first, and every byte goes out MSB first. MOSI is low during dummy bytes and during the data phase.
- R6: SCK idles low (SPI mode 0). MOSI changes only after a falling SCK edge, MISO is sampled on the rising edge, and each received byte is assembled with the first bit in bit 7.
- R7: Exactly `req_len_m1`+1 bytes are read, and then chip select is raised with no further command. No address wrap is applied by the host, so a burst that runs past address 0xFFFFFF continues with the bytes the flash returns from address 0.
- R8: A byte on `rd_data` stays stable with `rd_valid` high until `rd_ready` accepts it. While a byte waits unaccepted, SCK does not change.
- R9: Chip select falls at least one SCK half-period before the first rising SCK edge, and rises at least one half-period after the last falling edge. SCK is low whenever chip select is high.
- R10: After reset, `spi_cs_n` is high, `spi_sck` and `spi_mosi` are low, `busy` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 24 | First byte address of the burst |
| req_len_m1 | input | LEN_W | Number of bytes to read, minus one |
| req_mode | input | 2 | Read flavour: 0 fast, 1 high-speed, 2 or 3 slow |
| busy | output | 1 | Transfer in progress |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte present |
| rd_ready | input | 1 | Consumer accepts the byte |

## Verification
The bench builds the block with FAST_HALF=2, SLOW_HALF=3 and LEN_W=6. A short, unequal pair of half-periods makes the slow and fast clock rates tell apart in a few cycles of every transfer. A six-bit length field allows bursts of up to 64 bytes, so the tests can run bursts of several bytes across the 0xFFFFFF-to-0 wrap and long back-pressured streams within a small cycle budget. A behavioural flash model on the pins decodes the command, the address and the dummy bits, measures the SCK half-periods and chip-select margins, and returns address-derived data that the scoreboard predicts.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  localparam int unsigned ADDR_BYTES = 3;
  localparam int unsigned ADDR_W     = 8 * ADDR_BYTES;
  localparam int unsigned MAX_DUMMY  = 2;
  localparam int unsigned TX_W       = 8 + ADDR_W + 8 * MAX_DUMMY;

  typedef enum logic [1:0] {
    RM_FAST     = 2'd0,
    RM_HISPEED  = 2'd1,
    RM_SLOW     = 2'd2,
    RM_SLOW_ALT = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } seq_state_e;

  function automatic logic [7:0] mode_opcode(input logic [1:0] m);
    logic [7:0] op;
    case (rd_mode_e'(m))
      RM_FAST:    op = 8'h0B;
      RM_HISPEED: op = 8'h1B;
      default:    op = 8'h03;
    endcase
    return op;
  endfunction

  function automatic logic [1:0] mode_dummies(input logic [1:0] m);
    logic [1:0] n;
    case (rd_mode_e'(m))
      RM_FAST:    n = 2'd1;
      RM_HISPEED: n = 2'd2;
      default:    n = 2'd0;
    endcase
    return n;
  endfunction

  function automatic logic mode_is_slow(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int unsigned FAST_HALF = 2,
  parameter int unsigned SLOW_HALF = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow_sel,
  input  logic hold,
  output logic tick
);

  localparam int unsigned MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int unsigned CW   = (MAXH > 1) ? $clog2(MAXH) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] lim;

  assign lim = slow_sel ? CW'(SLOW_HALF - 1) : CW'(FAST_HALF - 1);

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (!hold) begin
      if (cnt_q == lim) begin
        tick  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_out
);

  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = load_val;
    else if (shift) sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign bit_out = sh_q[W-1];

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          bit_in,
  output logic [DW-1:0] word_next
);

  logic [DW-1:0] sh_q;

  assign word_next = {sh_q[DW-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (sample) sh_q <= word_next;
  end

endmodule

// File: rtl/spi_burst_reader.sv
module spi_burst_reader
  import spi_rd_pkg::*;
#(
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned FAST_HALF = 2,
  parameter int unsigned SLOW_HALF = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [23:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len_m1,
  input  logic [1:0]        req_mode,
  output logic              busy,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready
);

  localparam int unsigned HDR_CW = $clog2(TX_W + 1);

  seq_state_e        state_q, state_d;
  logic              sck_q, sck_d;
  logic [HDR_CW-1:0] hdr_q, hdr_d;
  logic [2:0]        bit_q, bit_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              last_q, last_d;
  logic              slow_q, slow_d;
  logic [7:0]        dout_q, dout_d;
  logic              dvld_q, dvld_d;

  logic              tick;
  logic              pause;
  logic              run;
  logic              tx_load;
  logic              tx_shift;
  logic              rx_sample;
  logic              dvld_set;
  logic [TX_W-1:0]   tx_frame;
  logic [7:0]        rx_next;

  assign run      = (state_q != ST_IDLE);
  assign pause    = dvld_q && !rd_ready;
  assign tx_frame = {mode_opcode(req_mode), req_addr, {(8 * MAX_DUMMY){1'b0}}};

  spi_sck_div #(
    .FAST_HALF (FAST_HALF),
    .SLOW_HALF (SLOW_HALF)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .slow_sel (slow_q),
    .hold     (pause),
    .tick     (tick)
  );

  spi_tx_shift #(
    .W (TX_W)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tx_load),
    .load_val (tx_frame),
    .shift    (tx_shift),
    .bit_out  (spi_mosi)
  );

  spi_rx_shift #(
    .DW (8)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (rx_sample),
    .bit_in    (spi_miso),
    .word_next (rx_next)
  );

  always_comb begin
    state_d   = state_q;
    sck_d     = sck_q;
    hdr_d     = hdr_q;
    bit_d     = bit_q;
    left_d    = left_q;
    last_d    = last_q;
    slow_d    = slow_q;
    dout_d    = dout_q;
    tx_load   = 1'b0;
    tx_shift  = 1'b0;
    rx_sample = 1'b0;
    dvld_set  = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_SETUP;
          tx_load = 1'b1;
          hdr_d   = HDR_CW'(8 + ADDR_W) + HDR_CW'({mode_dummies(req_mode), 3'b000});
          bit_d   = 3'd0;
          left_d  = req_len_m1;
          last_d  = 1'b0;
          slow_d  = mode_is_slow(req_mode);
        end
      end
      ST_SETUP: begin
        if (tick) state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
            if (hdr_q != '0) begin
              hdr_d = hdr_q - 1'b1;
            end else begin
              rx_sample = 1'b1;
              bit_d     = bit_q + 3'd1;
              if (bit_q == 3'd7) begin
                dout_d   = rx_next;
                dvld_set = 1'b1;
                if (left_q == '0) last_d = 1'b1;
                else              left_d = left_q - 1'b1;
              end
            end
          end else begin
            sck_d    = 1'b0;
            tx_shift = 1'b1;
            if (last_q) state_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (tick) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    dvld_d = dvld_q;
    if (dvld_set)              dvld_d = 1'b1;
    else if (dvld_q && rd_ready) dvld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      hdr_q   <= '0;
      bit_q   <= 3'd0;
      left_q  <= '0;
      last_q  <= 1'b0;
      slow_q  <= 1'b0;
      dout_q  <= 8'h00;
      dvld_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      hdr_q   <= hdr_d;
      bit_q   <= bit_d;
      left_q  <= left_d;
      last_q  <= last_d;
      slow_q  <= slow_d;
      dout_q  <= dout_d;
      dvld_q  <= dvld_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = run;
  assign spi_cs_n  = !run;
  assign spi_sck   = sck_q;
  assign rd_data   = dout_q;
  assign rd_valid  = dvld_q;

endmodule

// File: rtl/spi_burst_reader_chk.sv
module spi_burst_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       busy,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready
);

  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  a_r1_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  a_r1_busy_ends_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> spi_cs_n);

  a_r6_mosi_still_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi));

  a_r6_mosi_still_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  a_r8_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  a_r8_freeze_sck: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> $stable(spi_sck));

  a_r9_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r9_cs_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |=> !spi_sck);

  a_r9_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !$past(spi_sck));

endmodule

bind spi_burst_reader spi_burst_reader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .spi_cs_n  (spi_cs_n),
  .spi_sck   (spi_sck),
  .spi_mosi  (spi_mosi),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready)
);

// File: tb/spi_burst_reader_test.sv
module spi_burst_reader_test;

  localparam int LEN_W     = 6;
  localparam int FAST_HALF = 2;
  localparam int SLOW_HALF = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [23:0]      req_addr = 24'h0;
  logic [LEN_W-1:0] req_len_m1 = '0;
  logic [1:0]       req_mode = 2'd0;
  logic             busy;
  logic             spi_cs_n;
  logic             spi_sck;
  logic             spi_mosi;
  logic             spi_miso = 1'b0;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic             rd_ready = 1'b1;

  always #2 clk = ~clk;

  spi_burst_reader #(
    .LEN_W     (LEN_W),
    .FAST_HALF (FAST_HALF),
    .SLOW_HALF (SLOW_HALF)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_len_m1 (req_len_m1),
    .req_mode   (req_mode),
    .busy       (busy),
    .spi_cs_n   (spi_cs_n),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int bp_mode = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check_eq(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_ge(input string req, input string what, input longint act, input longint lo);
    n_tests++;
    if (act < lo) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lo);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return {a[3:0], a[7:4]} ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // consumer back-pressure
  always @(posedge clk) begin
    #1;
    case (bp_mode)
      1:       rd_ready = ((cyc % 5) != 2) && ((cyc % 7) != 4);
      2:       rd_ready = 1'b0;
      default: rd_ready = 1'b1;
    endcase
  end

  // scoreboard monitor
  logic [7:0] exp_q[$];
  logic [7:0] exp_b;
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        check_eq("R7", "byte beyond requested count", 1, 0);
      end else begin
        exp_b = exp_q.pop_front();
        check_eq("R6", "received byte", rd_data, exp_b);
      end
    end
  end

  // flash model on the pins
  logic        p_cs = 1'b1;
  logic        p_sck = 1'b0;
  int          m_rise, m_hdr, m_last_edge, m_min_half, m_cs_fall, m_first_rise, m_last_fall, m_k;
  logic [7:0]  m_op, m_b;
  logic [23:0] m_addr;
  bit          m_dummy_bad, m_data_bad;
  int          r_rise, r_hdr, r_min_half, r_setup, r_hold;
  logic [7:0]  r_op;
  logic [23:0] r_addr;
  bit          r_dummy_bad, r_data_bad;
  int          txn_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cs && !spi_cs_n) begin
        m_rise = 0; m_hdr = 48; m_op = 8'h00; m_addr = 24'h0;
        m_dummy_bad = 0; m_data_bad = 0;
        m_last_edge = -1; m_min_half = 1000000;
        m_cs_fall = cyc; m_first_rise = -1; m_last_fall = cyc;
      end
      if (!spi_cs_n && !p_sck && spi_sck) begin
        if (m_last_edge >= 0 && (cyc - m_last_edge) < m_min_half) m_min_half = cyc - m_last_edge;
        m_last_edge = cyc;
        if (m_first_rise < 0) m_first_rise = cyc;
        if (m_rise < 8)            m_op = {m_op[6:0], spi_mosi};
        else if (m_rise < 32)      m_addr = {m_addr[22:0], spi_mosi};
        else if (m_rise < m_hdr) begin if (spi_mosi) m_dummy_bad = 1; end
        else if (spi_mosi)         m_data_bad = 1;
        m_rise++;
        if (m_rise == 8) m_hdr = (m_op == 8'h1B) ? 48 : (m_op == 8'h0B) ? 40 : 32;
      end
      if (!spi_cs_n && p_sck && !spi_sck) begin
        if (m_last_edge >= 0 && (cyc - m_last_edge) < m_min_half) m_min_half = cyc - m_last_edge;
        m_last_edge = cyc;
        m_last_fall = cyc;
        if (m_rise >= 32 && m_rise >= m_hdr) begin
          m_k = m_rise - m_hdr;
          m_b = mem_byte(m_addr + 24'(m_k / 8));
          spi_miso = m_b[7 - (m_k % 8)];
        end
      end
      if (!p_cs && spi_cs_n) begin
        r_rise = m_rise; r_hdr = m_hdr; r_op = m_op; r_addr = m_addr;
        r_dummy_bad = m_dummy_bad; r_data_bad = m_data_bad;
        r_min_half = m_min_half; r_setup = m_first_rise - m_cs_fall;
        r_hold = cyc - m_last_fall;
        txn_cnt++;
      end
      p_cs  = spi_cs_n;
      p_sck = spi_sck;
    end
  end

  // driver: pushes expectations, issues one burst and checks the pin record
  task automatic run_read(input logic [1:0] mode, input logic [23:0] addr, input int nbytes,
                          input int exp_op, input int half, input string rq,
                          input bit stall_probe, input bit poke_busy);
    int t0;
    logic [7:0] d0;
    logic s0;
    t0 = txn_cnt;
    for (int i = 0; i < nbytes; i++) exp_q.push_back(mem_byte(addr + 24'(i)));
    @(negedge clk);
    check_eq("R1", "req_ready while idle", req_ready, 1);
    req_valid = 1'b1; req_addr = addr; req_len_m1 = LEN_W'(nbytes - 1); req_mode = mode;
    @(negedge clk);
    check_eq("R1", "busy after accept", busy, 1);
    check_eq("R1", "req_ready while busy", req_ready, 0);
    if (poke_busy) begin
      req_addr = 24'h777777; req_mode = 2'd1;
      for (int i = 0; i < 30; i++) @(negedge clk);
      check_eq("R1", "req_ready while busy and requested", req_ready, 0);
    end
    req_valid = 1'b0;
    if (stall_probe) begin
      bp_mode = 2;
      for (int i = 0; i < 3000 && !rd_valid; i++) @(negedge clk);
      d0 = rd_data; s0 = spi_sck;
      for (int i = 0; i < 60; i++) @(negedge clk);
      check_eq("R8", "rd_valid held under stall", rd_valid, 1);
      check_eq("R8", "rd_data held under stall", rd_data, d0);
      check_eq("R8", "sck frozen under stall", spi_sck, s0);
      bp_mode = 0;
    end
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    for (int i = 0; i < 2000 && (exp_q.size() != 0 || rd_valid); i++) @(negedge clk);
    @(negedge clk);
    check_eq("R1", "one transfer per request", txn_cnt, t0 + 1);
    check_eq(rq, "command byte", r_op, exp_op);
    check_eq("R5", "address sent", r_addr, addr);
    check_eq("R5", "dummy bits low", r_dummy_bad, 0);
    check_eq("R5", "mosi low in data phase", r_data_bad, 0);
    check_eq("R7", "data clocks", r_rise - r_hdr, nbytes * 8);
    check_eq(rq, "sck half period", r_min_half, half);
    check_ge("R9", "cs setup", r_setup, half);
    check_ge("R9", "cs hold", r_hold, half);
    check_eq("R9", "sck low after release", spi_sck, 0);
    check_eq("R7", "all bytes delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check_eq("R1", "watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R10", "cs_n in reset", spi_cs_n, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R10", "cs_n", spi_cs_n, 1);
    check_eq("R10", "sck", spi_sck, 0);
    check_eq("R10", "mosi", spi_mosi, 0);
    check_eq("R10", "busy", busy, 0);
    check_eq("R10", "rd_valid", rd_valid, 0);
    check_eq("R10", "req_ready", req_ready, 1);

    run_read(2'd0, 24'h123456, 4, 8'h0B, FAST_HALF, "R2", 0, 0);
    run_read(2'd1, 24'hA5C3F0, 3, 8'h1B, FAST_HALF, "R3", 0, 0);
    run_read(2'd2, 24'h00ABCD, 2, 8'h03, SLOW_HALF, "R4", 0, 0);
    run_read(2'd3, 24'h3C0F81, 3, 8'h03, SLOW_HALF, "R4", 0, 0);
    run_read(2'd0, 24'hFFFFFD, 6, 8'h0B, FAST_HALF, "R7", 0, 0);
    run_read(2'd0, 24'h000100, 1, 8'h0B, FAST_HALF, "R7", 0, 0);
    bp_mode = 1;
    run_read(2'd1, 24'h4455AA, 16, 8'h1B, FAST_HALF, "R8", 0, 0);
    bp_mode = 0;
    run_read(2'd0, 24'h0F0F0F, 3, 8'h0B, FAST_HALF, "R8", 1, 0);
    run_read(2'd2, 24'h5A5A00, 2, 8'h03, SLOW_HALF, "R1", 0, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule